// File: doc/BRIEF.md
# Decoded RAM and ROM Memory Subsystem

This block is the memory side of a small processor bus. A 10-bit address, an 8-bit write byte and two strobes (read and write) come in. They are decoded onto five devices: four 128-byte RAM banks and one 512-byte ROM. Each device is gated by a pair of chip selects. One select is active high and the other is active low. A device does nothing unless both selects agree. When a device is selected and both strobes are high, the read wins.

The top address bit splits the space into two halves. The lower half goes to RAM, and a 2-to-4 decoder picks the bank. That decoder is enabled only when the top bit is clear. The upper half goes to the ROM, whose contents are computed by a fixed formula in the logic. There is no tristate bus. A read returns its byte one clock later, together with a one-cycle valid flag that also serves as the output enable. Outside a valid cycle the returned byte is forced to zero.

Top module: `mem_subsys_top`

## Requirements
- R1: While reset (rst_n low at a rising edge) is applied, bus_rvalid and bus_rdata are 0 after that edge.
- R2: A cycle with bus_rd=1 at a rising edge produces bus_rvalid=1 for exactly the following cycle, with the addressed byte on bus_rdata; every address is mapped, so every read returns a byte.
- R3: Addresses 0x000-0x1FF (bus_addr[9]=0) map to RAM. bus_addr[8:7] selects the bank: 0 covers 0x000-0x07F, 1 covers 0x080-0x0FF, 2 covers 0x100-0x17F, and 3 covers 0x180-0x1FF. bus_addr[6:0] is the byte within the bank, and the banks do not alias one another.
- R4: A cycle with bus_wr=1, bus_rd=0 and bus_addr[9]=0 stores bus_wdata at the rising edge. A later read of that address returns it.
- R5: When bus_rd=1 and bus_wr=1 together, the cycle is a read: it returns the previous contents and stores nothing.
- R6: A cycle with bus_rd=0 and bus_wr=0 changes no memory, and bus_rvalid is 0 in the following cycle.
- R7: Addresses 0x200-0x3FF (bus_addr[9]=1) read the ROM. The ROM uses bus_addr[8:0], and its byte is ((bus_addr[7:0]*5+3) mod 256) XOR (bus_addr[8] ? 0xA5 : 0x00).
- R8: A write to 0x200-0x3FF changes neither the ROM nor the RAM byte at the same low address bits, and it yields no valid.
- R9: bus_rdata is 0 in every cycle where bus_rvalid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe, wins over bus_wr |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read byte, zero when not valid |
| bus_rvalid | output | 1 | One-cycle read valid / output enable |

## Verification
The hardest case to reach is a collision on one address. One collision is a cycle with both strobes high on a RAM byte. The other is a write into the ROM half whose low nine bits equal those of a RAM byte already holding data. Both cases can only be judged against known prior contents. The stimulus therefore first fills each bank at the same offset with distinct bytes. It then drives both strobes, or a high-half write, at that offset. Finally it reads the RAM byte and the ROM byte back to confirm that nothing moved.

// File: rtl/mem_map_pkg.sv
`timescale 1ns/1ps
// Shared widths, chip-select type, per-device operation decode and the ROM
// content formula. Assumes a 10-bit byte address split into two halves.
package mem_map_pkg;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 8;
    localparam int BANK_AW = 7;
    localparam int ROM_AW  = 9;
    localparam int N_BANKS = 4;
    localparam logic [DATA_W-1:0] ROM_MUL    = 8'd5;
    localparam logic [DATA_W-1:0] ROM_ADD    = 8'd3;
    localparam logic [DATA_W-1:0] ROM_HI_XOR = 8'hA5;

    // Two chip selects per device: one active high, one active low.
    typedef struct packed {
        logic cs_hi;
        logic cs_lo_n;
    } chip_sel_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } dev_op_t;

    // Function table of one device: selected only for cs_hi=1, cs_lo_n=0;
    // read has precedence over write.
    function automatic dev_op_t dev_op(chip_sel_t s, logic rd, logic wr);
        dev_op_t r;
        if (!(s.cs_hi && !s.cs_lo_n)) r = OP_IDLE;
        else if (rd)                  r = OP_READ;
        else if (wr)                  r = OP_WRITE;
        else                          r = OP_IDLE;
        return r;
    endfunction

    // ROM byte for a 9-bit internal address.
    function automatic logic [DATA_W-1:0] rom_value(logic [ROM_AW-1:0] a);
        logic [DATA_W-1:0] base;
        base = a[DATA_W-1:0] * ROM_MUL + ROM_ADD;
        return base ^ (a[ROM_AW-1] ? ROM_HI_XOR : '0);
    endfunction
endpackage

// File: rtl/bank_decoder.sv
`timescale 1ns/1ps
// Enabled N-way one-hot decoder driving the active-high RAM chip selects.
// Assumes N_OUT <= 2**SEL_W.
module bank_decoder #(
    parameter int N_OUT = 4,
    parameter int SEL_W = $clog2(N_OUT)
) (
    input  logic             en,
    input  logic [SEL_W-1:0] code,
    output logic [N_OUT-1:0] hit
);
    // One output line per bank, high when enabled and the code matches.
    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign hit[g] = en && (code == SEL_W'(g));
    end
endmodule

// File: rtl/ram_bank.sv
`timescale 1ns/1ps
// One RAM bank with two chip selects. Writes land on the rising edge; a read
// registers the byte and a one-cycle valid. Contents are not reset.
module ram_bank
    import mem_map_pkg::*;
#(
    parameter int AW = BANK_AW,
    parameter int DW = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chip_sel_t     sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] mem [DEPTH];
    dev_op_t op;

    // Decode this device's operation from its selects and strobes.
    assign op = dev_op(sel, rd, wr);

    // Store the write byte when the decoded operation is a write.
    always_ff @(posedge clk) begin
        if (op == OP_WRITE) mem[addr] <= wdata;
    end

    // Register the read byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (op == OP_READ);
            if (op == OP_READ) rdata <= mem[addr];
        end
    end

    // R4
    ram_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> mem[$past(addr)] == $past(wdata));
    // R5
    ram_read_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && wr) |=> mem[$past(addr)] == $past(mem[addr]));
endmodule

// File: rtl/rom_bank.sv
`timescale 1ns/1ps
// ROM with two chip selects; contents come from the package formula.
// A write decodes to a no-op. Output registered like the RAM banks.
module rom_bank
    import mem_map_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chip_sel_t     sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    dev_op_t op;

    // Decode the operation; OP_WRITE has no effect on a ROM.
    assign op = dev_op(sel, rd, wr);

    // Register the computed ROM byte and valid on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= (op == OP_READ);
            if (op == OP_READ) rdata <= rom_value(addr);
        end
    end

    // R8
    rom_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !rvalid);
endmodule

// File: rtl/mem_subsys_top.sv
`timescale 1ns/1ps
// Decoded memory subsystem: four RAM banks in the lower half of a 10-bit
// space and one ROM in the upper half. The read byte is the OR of the
// device outputs masked by their one-hot valids, so it is zero when idle.
module mem_subsys_top
    import mem_map_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int NB  = N_BANKS,
    parameter int BAW = BANK_AW,
    localparam int SEL_W = $clog2(NB),
    localparam int RAW   = AW - 1,
    localparam int NDEV  = NB + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rvalid
);
    logic            hi_half;
    logic [NB-1:0]   bank_hit;
    logic [NDEV-1:0] dev_vld;
    logic [DW-1:0]   dev_data [NDEV];
    chip_sel_t       rom_sel;

    // The top address bit picks ROM over RAM.
    assign hi_half = bus_addr[AW-1];

    bank_decoder #(.N_OUT(NB), .SEL_W(SEL_W)) u_dec (
        .en   (!hi_half),
        .code (bus_addr[BAW +: SEL_W]),
        .hit  (bank_hit)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        chip_sel_t s;
        // Bank select: decoder line high, RAM half (active-low select).
        assign s.cs_hi   = bank_hit[b];
        assign s.cs_lo_n = hi_half;
        ram_bank #(.AW(BAW), .DW(DW)) u_ram (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (s),
            .rd     (bus_rd),
            .wr     (bus_wr),
            .addr   (bus_addr[BAW-1:0]),
            .wdata  (bus_wdata),
            .rdata  (dev_data[b]),
            .rvalid (dev_vld[b])
        );
    end

    // ROM select: top address bit high, active-low select tied active.
    assign rom_sel.cs_hi   = hi_half;
    assign rom_sel.cs_lo_n = 1'b0;

    rom_bank #(.AW(RAW), .DW(DW)) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (rom_sel),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .addr   (bus_addr[RAW-1:0]),
        .rdata  (dev_data[NB]),
        .rvalid (dev_vld[NB])
    );

    // Merge device outputs: masked OR, zero when no device is valid.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_vld[i]) bus_rdata = bus_rdata | dev_data[i];
        end
        bus_rvalid = |dev_vld;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_rvalid && bus_rdata == '0));
    // R2
    read_gets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    // R6
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R3
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_vld));
    // R3
    bank_by_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hi_half) |=> dev_vld[$past(bus_addr[BAW +: SEL_W])]);
    // R7
    rom_serves_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hi_half) |=> dev_vld[NB]);
endmodule

// File: tb/mem_subsys_top_bench.sv
`timescale 1ns/1ps
module mem_subsys_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       vld;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb[$];
    logic [7:0] model [512];

    always #5 clk = ~clk;

    mem_subsys_top u_mem_subsys_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    // ROM content per R7
    function automatic logic [7:0] rom_expect(logic [9:0] a);
        logic [7:0] v;
        v = 8'((int'(a[7:0]) * 5 + 3) % 256);
        return a[8] ? (v ^ 8'hA5) : v;
    endfunction

    // Driver: one bus cycle, pushes the expected result of the next cycle.
    task automatic bus_cycle(input logic [9:0] a, input logic [7:0] wd,
                             input logic rd, input logic wr, input string tag);
        exp_t e;
        @(negedge clk);
        #2;
        bus_addr = a; bus_wdata = wd; bus_rd = rd; bus_wr = wr;
        e.tag = tag;
        if (rd) begin
            e.vld  = 1'b1;
            e.data = a[9] ? rom_expect(a) : model[a[8:0]];
        end else begin
            e.vld  = 1'b0;
            e.data = 8'h00;
            if (wr && !a[9]) model[a[8:0]] = wd;
        end
        sb.push_back(e);
    endtask

    // Monitor: compares outputs one cycle after each driven cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bus_rvalid !== e.vld || bus_rdata !== e.data) begin
                    bad++;
                    $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                             e.tag, bus_rvalid, bus_rdata, e.vld, e.data);
                end
            end else if (rst_n && bus_rvalid !== 1'b0) begin
                checks++;
                bad++;
                $display("FAIL R2: got unexpected valid=%0b, expected 0", bus_rvalid);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (bus_rvalid !== 1'b0 || bus_rdata !== 8'h00) begin
            bad++;
            $display("FAIL R1: got valid=%0b data=%02h, expected valid=0 data=00",
                     bus_rvalid, bus_rdata);
        end
        #2 rst_n = 1'b1;

        // R3/R4: same offset in every bank, plus bank edges
        bus_cycle(10'h005, 8'h11, 1'b0, 1'b1, "R4");
        bus_cycle(10'h085, 8'h22, 1'b0, 1'b1, "R4");
        bus_cycle(10'h105, 8'h33, 1'b0, 1'b1, "R4");
        bus_cycle(10'h185, 8'h44, 1'b0, 1'b1, "R4");
        bus_cycle(10'h07F, 8'h5A, 1'b0, 1'b1, "R4");
        bus_cycle(10'h080, 8'hA5, 1'b0, 1'b1, "R4");
        bus_cycle(10'h1FF, 8'hC3, 1'b0, 1'b1, "R4");
        bus_cycle(10'h005, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h085, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h105, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h185, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h07F, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h080, 8'h00, 1'b1, 1'b0, "R3");
        bus_cycle(10'h1FF, 8'h00, 1'b1, 1'b0, "R2");

        // R4: fill bank 2 with a pattern and read it back
        for (int i = 0; i < 128; i++)
            bus_cycle(10'(10'h100 + i), 8'(i * 3 + 7), 1'b0, 1'b1, "R4");
        for (int i = 0; i < 128; i++)
            bus_cycle(10'(10'h100 + i), 8'h00, 1'b1, 1'b0, "R4");

        // R5: both strobes -> read old byte, no store
        bus_cycle(10'h085, 8'hEE, 1'b1, 1'b1, "R5");
        bus_cycle(10'h085, 8'h00, 1'b1, 1'b0, "R5");

        // R6/R9: no strobes, data present; then readback unchanged
        bus_cycle(10'h185, 8'h77, 1'b0, 1'b0, "R6");
        bus_cycle(10'h000, 8'h00, 1'b0, 1'b0, "R9");
        bus_cycle(10'h185, 8'h00, 1'b1, 1'b0, "R6");

        // R7: ROM reads across the upper half
        bus_cycle(10'h200, 8'h00, 1'b1, 1'b0, "R7");
        bus_cycle(10'h2FF, 8'h00, 1'b1, 1'b0, "R7");
        bus_cycle(10'h300, 8'h00, 1'b1, 1'b0, "R7");
        bus_cycle(10'h37B, 8'h00, 1'b1, 1'b0, "R7");
        bus_cycle(10'h3FF, 8'h00, 1'b1, 1'b0, "R7");

        // R8: write into ROM half aliasing RAM offsets 0x005 and 0x185
        bus_cycle(10'h205, 8'h99, 1'b0, 1'b1, "R8");
        bus_cycle(10'h385, 8'h99, 1'b0, 1'b1, "R8");
        bus_cycle(10'h205, 8'h00, 1'b1, 1'b0, "R8");
        bus_cycle(10'h385, 8'h00, 1'b1, 1'b0, "R8");
        bus_cycle(10'h005, 8'h00, 1'b1, 1'b0, "R8");
        bus_cycle(10'h185, 8'h00, 1'b1, 1'b0, "R8");

        // drain
        bus_cycle(10'h000, 8'h00, 1'b0, 1'b0, "R9");
        bus_cycle(10'h000, 8'h00, 1'b0, 1'b0, "R9");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule